// File: doc/BRIEF.md
# Relocatable Two-Bank Overlay RAM Mapper

This block sits between an emulated processor's bus and the memory of the system under test. It holds two 4 KB banks of substitute RAM. Each bank can be placed on any 4 KB page of a 16-bit address space and set to off, read-only or read/write. On every target bus cycle the mapper decides, from the address alone, whether a bank answers and whether the system's own memory must be held off. A write is accepted only when the answering bank is writable. The decision is made in the same cycle as the access.

A second, privileged port belongs to the debug host. It can read any bank and write any bank whatever that bank's mode, which is how code is loaded into a window that the target sees as read-only. The storage in the project is a behavioural model. Its per-bank depth is a parameter, and a 4 KB offset wraps onto it. Bank contents are never cleared, so they survive while a bank is off and show again when the bank is turned back on.

Top module: `ovl_mapper`

## Requirements
- R1: A bank whose mode enables it answers a target cycle (read or write strobe high) when address bits [15:12] equal its 4-bit position. The bank then asserts `ovl_cs_o` and `tgt_inhibit_o` together in that same cycle. Addresses outside every enabled window leave both low.
- R2: Mode encoding is 2'b00 off, 2'b01 read-only, 2'b11 read/write, and 2'b10 acts as off. A cycle aimed at a disabled bank falls through to target memory (no select, no inhibit), or goes to the other bank if that one covers the page.
- R3: When both banks cover the addressed page, bank A (index 0) answers, whatever the modes of the two banks.
- R4: `ovl_addr_o` is the answering bank index in bit 12 followed by target address bits [11:0].
- R5: A target write to a read/write window raises `ovl_we_o`, and the written byte is returned by a target read of that address from the next cycle on.
- R6: A target write to a read-only window keeps `ovl_we_o` low and `tgt_inhibit_o` high, so the write is dropped and leaves the bank contents unchanged.
- R7: Writes on the privileged port land in the selected bank whatever its mode (off, read-only or read/write). `emu_rdata_o` shows any bank word at once.
- R8: Bank contents persist while the bank is off, and they appear again to target reads once it is re-enabled.
- R9: If a target write and a privileged write hit the same word in one cycle, the privileged data is stored.
- R10: With neither strobe high, all three control outputs stay low. While reset is asserted, no write of either port changes the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for storage writes |
| rst_ni | input | 1 | Active-low reset; blocks writes |
| tgt_addr_i | input | 16 | Target bus address |
| tgt_rd_i | input | 1 | Target read strobe |
| tgt_wr_i | input | 1 | Target write strobe |
| tgt_wdata_i | input | 8 | Target write data |
| bank_pos_i | input | 8 | 4-bit page per bank, bank A in bits [3:0] |
| bank_mode_i | input | 4 | 2-bit mode per bank, bank A in bits [1:0] |
| emu_we_i | input | 1 | Privileged write strobe |
| emu_bank_i | input | 1 | Privileged bank select |
| emu_ofs_i | input | 6 | Privileged word offset in model storage |
| emu_wdata_i | input | 8 | Privileged write data |
| ovl_cs_o | output | 1 | Overlay answers this cycle |
| ovl_we_o | output | 1 | Overlay write accepted |
| tgt_inhibit_o | output | 1 | Hold target memory off the bus |
| ovl_addr_o | output | 13 | Bank index and 12-bit offset |
| ovl_rdata_o | output | 8 | Overlay data for target reads |
| emu_rdata_o | output | 8 | Privileged read data |

## Verification
Two functions can meet in one cycle: a target write accepted by a read/write window and a privileged write aimed at the same storage word. The bench enables bank A read/write, drives both strobes for one clock at the same offset with different bytes, and then reads the word back through both the target path and the privileged path. Only the privileged byte is accepted. A second case does the same with the bank read-only, so that only the privileged write could have landed.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;

   typedef enum logic [1:0] {
      MODE_OFF     = 2'b00,
      MODE_RO      = 2'b01,
      MODE_OFF_ALT = 2'b10,
      MODE_RW      = 2'b11
   } ovl_mode_e;

   function automatic logic mode_enabled(input logic [1:0] m);
      return (m == MODE_RO) || (m == MODE_RW);
   endfunction

   function automatic logic mode_writable(input logic [1:0] m);
      return m == MODE_RW;
   endfunction

endpackage

// File: rtl/ovl_window_match.sv
`timescale 1ns/1ps
module ovl_window_match #(
   parameter int PAGE_W = 4
) (
   input  logic [PAGE_W-1:0] page_i,
   input  logic [PAGE_W-1:0] pos_i,
   input  logic [1:0]        mode_i,
   input  logic              cycle_i,
   output logic              hit_o,
   output logic              writable_o
);
   import ovl_pkg::*;

   logic page_eq;

   always_comb begin
      page_eq    = (page_i == pos_i);
      hit_o      = cycle_i && page_eq && mode_enabled(mode_i);
      writable_o = mode_writable(mode_i);
   end

endmodule

// File: rtl/ovl_prio_sel.sv
`timescale 1ns/1ps
module ovl_prio_sel #(
   parameter int NUM_BANKS = 2,
   localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic [NUM_BANKS-1:0] hit_i,
   output logic                 any_o,
   output logic [BSEL_W-1:0]    idx_o
);

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--) begin
         if (hit_i[i]) begin
            any_o = 1'b1;
            idx_o = BSEL_W'(i);
         end
      end
   end

endmodule

// File: rtl/ovl_store.sv
`timescale 1ns/1ps
module ovl_store #(
   parameter int NUM_BANKS = 2,
   parameter int STORE_AW  = 6,
   parameter int DATA_W    = 8,
   localparam int BSEL_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int DEPTH    = 1 << STORE_AW
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                t_we_i,
   input  logic [BSEL_W-1:0]   t_bank_i,
   input  logic [STORE_AW-1:0] t_ofs_i,
   input  logic [DATA_W-1:0]   t_wdata_i,
   output logic [DATA_W-1:0]   t_rdata_o,
   input  logic                e_we_i,
   input  logic [BSEL_W-1:0]   e_bank_i,
   input  logic [STORE_AW-1:0] e_ofs_i,
   input  logic [DATA_W-1:0]   e_wdata_i,
   output logic [DATA_W-1:0]   e_rdata_o
);

   logic [DATA_W-1:0] rd_t [NUM_BANKS];
   logic [DATA_W-1:0] rd_e [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [DATA_W-1:0] mem [DEPTH];
      logic              t_sel;
      logic              e_sel;

      assign t_sel = t_we_i && (t_bank_i == BSEL_W'(b));
      assign e_sel = e_we_i && (e_bank_i == BSEL_W'(b));

      always_ff @(posedge clk_i) begin
         if (rst_ni) begin
            if (t_sel && !(e_sel && (e_ofs_i == t_ofs_i)))
               mem[t_ofs_i] <= t_wdata_i;
            if (e_sel)
               mem[e_ofs_i] <= e_wdata_i;
         end
      end

      assign rd_t[b] = mem[t_ofs_i];
      assign rd_e[b] = mem[e_ofs_i];
   end

   assign t_rdata_o = rd_t[t_bank_i];
   assign e_rdata_o = rd_e[e_bank_i];

endmodule

// File: rtl/ovl_mapper.sv
`timescale 1ns/1ps
module ovl_mapper #(
   parameter int NUM_BANKS  = 2,
   parameter int ADDR_W     = 16,
   parameter int BANK_OFS_W = 12,
   parameter int STORE_AW   = 6,
   parameter int DATA_W     = 8,
   localparam int PAGE_W    = ADDR_W - BANK_OFS_W,
   localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int OADDR_W   = BSEL_W + BANK_OFS_W
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [ADDR_W-1:0]         tgt_addr_i,
   input  logic                      tgt_rd_i,
   input  logic                      tgt_wr_i,
   input  logic [DATA_W-1:0]         tgt_wdata_i,
   input  logic [NUM_BANKS*PAGE_W-1:0] bank_pos_i,
   input  logic [NUM_BANKS*2-1:0]    bank_mode_i,
   input  logic                      emu_we_i,
   input  logic [BSEL_W-1:0]         emu_bank_i,
   input  logic [STORE_AW-1:0]       emu_ofs_i,
   input  logic [DATA_W-1:0]         emu_wdata_i,
   output logic                      ovl_cs_o,
   output logic                      ovl_we_o,
   output logic                      tgt_inhibit_o,
   output logic [OADDR_W-1:0]        ovl_addr_o,
   output logic [DATA_W-1:0]         ovl_rdata_o,
   output logic [DATA_W-1:0]         emu_rdata_o
);

   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("ovl_mapper: NUM_BANKS must be at least 2");
   end
   if (BANK_OFS_W >= ADDR_W) begin : g_bad_ofs
      $error("ovl_mapper: BANK_OFS_W must be below ADDR_W");
   end
   if (STORE_AW > BANK_OFS_W) begin : g_bad_store
      $error("ovl_mapper: STORE_AW must not exceed BANK_OFS_W");
   end

   logic [PAGE_W-1:0]    page;
   logic                 cycle;
   logic [NUM_BANKS-1:0] hit;
   logic [NUM_BANKS-1:0] writable;
   logic                 any_hit;
   logic [BSEL_W-1:0]    sel_bank;
   logic                 sel_writable;

   assign page  = tgt_addr_i[ADDR_W-1:BANK_OFS_W];
   assign cycle = tgt_rd_i || tgt_wr_i;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_win
      ovl_window_match #(.PAGE_W(PAGE_W)) u_match (
         .page_i     (page),
         .pos_i      (bank_pos_i[b*PAGE_W +: PAGE_W]),
         .mode_i     (bank_mode_i[b*2 +: 2]),
         .cycle_i    (cycle),
         .hit_o      (hit[b]),
         .writable_o (writable[b])
      );
   end

   ovl_prio_sel #(.NUM_BANKS(NUM_BANKS)) u_prio (
      .hit_i (hit),
      .any_o (any_hit),
      .idx_o (sel_bank)
   );

   assign sel_writable  = writable[sel_bank];
   assign ovl_cs_o      = any_hit;
   assign tgt_inhibit_o = any_hit;
   assign ovl_we_o      = any_hit && tgt_wr_i && sel_writable;
   assign ovl_addr_o    = {sel_bank, tgt_addr_i[BANK_OFS_W-1:0]};

   ovl_store #(
      .NUM_BANKS (NUM_BANKS),
      .STORE_AW  (STORE_AW),
      .DATA_W    (DATA_W)
   ) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .t_we_i    (ovl_we_o),
      .t_bank_i  (sel_bank),
      .t_ofs_i   (tgt_addr_i[STORE_AW-1:0]),
      .t_wdata_i (tgt_wdata_i),
      .t_rdata_o (ovl_rdata_o),
      .e_we_i    (emu_we_i),
      .e_bank_i  (emu_bank_i),
      .e_ofs_i   (emu_ofs_i),
      .e_wdata_i (emu_wdata_i),
      .e_rdata_o (emu_rdata_o)
   );

endmodule

// File: rtl/ovl_mapper_chk.sv
`timescale 1ns/1ps
module ovl_mapper_chk #(
   parameter int NUM_BANKS  = 2,
   parameter int ADDR_W     = 16,
   parameter int BANK_OFS_W = 12,
   localparam int PAGE_W    = ADDR_W - BANK_OFS_W,
   localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int OADDR_W   = BSEL_W + BANK_OFS_W
) (
   input logic                        clk_i,
   input logic                        rst_ni,
   input logic [ADDR_W-1:0]           tgt_addr_i,
   input logic                        tgt_rd_i,
   input logic                        tgt_wr_i,
   input logic [NUM_BANKS*PAGE_W-1:0] bank_pos_i,
   input logic [NUM_BANKS*2-1:0]      bank_mode_i,
   input logic                        ovl_cs_o,
   input logic                        ovl_we_o,
   input logic                        tgt_inhibit_o,
   input logic [OADDR_W-1:0]          ovl_addr_o
);

   logic a_covers;
   logic none_enabled;

   always_comb begin
      a_covers = (tgt_rd_i || tgt_wr_i)
              && (tgt_addr_i[ADDR_W-1:BANK_OFS_W] == bank_pos_i[PAGE_W-1:0])
              && bank_mode_i[0];
      none_enabled = 1'b1;
      for (int i = 0; i < NUM_BANKS; i++)
         if (bank_mode_i[2*i]) none_enabled = 1'b0;
   end

   p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(tgt_rd_i || tgt_wr_i) |-> (!ovl_cs_o && !ovl_we_o && !tgt_inhibit_o));

   p_inhibit_with_cs_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovl_cs_o |-> tgt_inhibit_o);

   p_no_inhibit_alone_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tgt_inhibit_o |-> ovl_cs_o);

   p_all_off_through_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      none_enabled |-> !ovl_cs_o);

   p_bank_a_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_covers |-> (ovl_cs_o && ovl_addr_o[OADDR_W-1:BANK_OFS_W] == '0));

   p_offset_passes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovl_cs_o |-> (ovl_addr_o[BANK_OFS_W-1:0] == tgt_addr_i[BANK_OFS_W-1:0]));

   p_we_needs_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovl_we_o |-> (ovl_cs_o && tgt_wr_i));

   p_ro_blocks_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_covers && bank_mode_i[1:0] == 2'b01) |-> !ovl_we_o);

endmodule

bind ovl_mapper ovl_mapper_chk #(
   .NUM_BANKS  (NUM_BANKS),
   .ADDR_W     (ADDR_W),
   .BANK_OFS_W (BANK_OFS_W)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .tgt_addr_i    (tgt_addr_i),
   .tgt_rd_i      (tgt_rd_i),
   .tgt_wr_i      (tgt_wr_i),
   .bank_pos_i    (bank_pos_i),
   .bank_mode_i   (bank_mode_i),
   .ovl_cs_o      (ovl_cs_o),
   .ovl_we_o      (ovl_we_o),
   .tgt_inhibit_o (tgt_inhibit_o),
   .ovl_addr_o    (ovl_addr_o)
);

// File: tb/ovl_mapper_tb.sv
`timescale 1ns/1ps
module ovl_mapper_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        rd = 1'b0, wr = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  pos = '0;
   logic [3:0]  mode = '0;
   logic        e_we = 1'b0, e_bank = 1'b0;
   logic [5:0]  e_ofs = '0;
   logic [7:0]  e_wdata = '0;
   logic        cs, we, inh;
   logic [12:0] oaddr;
   logic [7:0]  ordata, erdata;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ovl_mapper dut_i (
      .clk_i (clk), .rst_ni (rst_n),
      .tgt_addr_i (addr), .tgt_rd_i (rd), .tgt_wr_i (wr), .tgt_wdata_i (wdata),
      .bank_pos_i (pos), .bank_mode_i (mode),
      .emu_we_i (e_we), .emu_bank_i (e_bank), .emu_ofs_i (e_ofs), .emu_wdata_i (e_wdata),
      .ovl_cs_o (cs), .ovl_we_o (we), .tgt_inhibit_o (inh),
      .ovl_addr_o (oaddr), .ovl_rdata_o (ordata), .emu_rdata_o (erdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // layout: posB modeB posA modeA addr rd wr | cs we bank
   localparam int NV = 10;
   localparam logic [32:0] VEC [NV] = '{
      {4'h0, 2'b00, 4'h3, 2'b11, 16'h3010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {4'h0, 2'b00, 4'h3, 2'b11, 16'h4010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      {4'h3, 2'b01, 4'h3, 2'b00, 16'h3ABC, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
      {4'h3, 2'b00, 4'h3, 2'b10, 16'h3000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
      {4'h5, 2'b11, 4'h5, 2'b01, 16'h5123, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
      {4'h5, 2'b11, 4'h5, 2'b11, 16'h5123, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
      {4'h9, 2'b00, 4'h0, 2'b01, 16'h0FFF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
      {4'hF, 2'b11, 4'h2, 2'b00, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
      {4'hF, 2'b11, 4'h2, 2'b00, 16'hEFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      {4'h0, 2'b00, 4'h3, 2'b11, 16'h3010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
   };

   task automatic drive_idle();
      rd = 1'b0; wr = 1'b0; e_we = 1'b0;
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R10: idle outputs and writes blocked in reset
      @(negedge clk);
      chk("R10 reset cs", {31'd0, cs}, 32'd0);
      chk("R10 reset inhibit", {31'd0, inh}, 32'd0);
      e_we = 1'b1; e_bank = 1'b0; e_ofs = 6'd9; e_wdata = 8'h5A;
      @(negedge clk);
      e_we = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      e_we = 1'b1; e_wdata = 8'h00;
      @(negedge clk);
      e_we = 1'b0;
      rst_n = 1'b0;
      e_we = 1'b1; e_wdata = 8'hC3;
      @(negedge clk);
      e_we = 1'b0;
      #1 chk("R10 write held off in reset", {24'd0, erdata}, 32'h00);
      rst_n = 1'b1;

      // vector table: R1 R2 R3 R4 R6 R10
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         pos  = {VEC[i][32:29], VEC[i][26:23]};
         mode = {VEC[i][28:27], VEC[i][22:21]};
         addr = VEC[i][20:5];
         rd   = VEC[i][4];
         wr   = VEC[i][3];
         wdata = 8'hEE;
         #1;
         chk($sformatf("R1 R2 R3 cs vec%0d", i), {31'd0, cs}, {31'd0, VEC[i][2]});
         chk($sformatf("R1 inhibit vec%0d", i), {31'd0, inh}, {31'd0, VEC[i][2]});
         chk($sformatf("R5 R6 we vec%0d", i), {31'd0, we}, {31'd0, VEC[i][1]});
         if (VEC[i][2])
            chk($sformatf("R3 R4 addr vec%0d", i), {19'd0, oaddr},
                {19'd0, VEC[i][0], VEC[i][16:5]});
         drive_idle();
      end

      // R7: privileged write into an off bank
      @(negedge clk);
      pos = 8'h72; mode = 4'b0000;
      e_we = 1'b1; e_bank = 1'b0; e_ofs = 6'd5; e_wdata = 8'hA5;
      @(negedge clk);
      e_we = 1'b0;
      #1 chk("R7 emu write off bank", {24'd0, erdata}, 32'hA5);

      // R8: enable read-only, target sees the byte
      mode = 4'b0001; addr = 16'h2005; rd = 1'b1;
      #1 chk("R8 visible after enable", {24'd0, ordata}, 32'hA5);

      // R6: read-only target write dropped
      @(negedge clk);
      rd = 1'b0; wr = 1'b1; wdata = 8'h11;
      #1 chk("R6 inhibit on ro write", {31'd0, inh}, 32'd1);
      @(negedge clk);
      wr = 1'b0; rd = 1'b1;
      #1 chk("R6 ro contents kept", {24'd0, ordata}, 32'hA5);

      // R5: read/write target write lands
      @(negedge clk);
      mode = 4'b0011; rd = 1'b0; wr = 1'b1; wdata = 8'h22;
      @(negedge clk);
      wr = 1'b0; rd = 1'b1;
      #1 chk("R5 rw write stored", {24'd0, ordata}, 32'h22);

      // R8: off then on again
      @(negedge clk);
      mode = 4'b0000;
      #1 chk("R2 off bank falls through", {31'd0, cs}, 32'd0);
      @(negedge clk);
      mode = 4'b0011;
      #1 chk("R8 retained after off", {24'd0, ordata}, 32'h22);

      // R9: same-word collision, privileged data wins
      @(negedge clk);
      rd = 1'b0; wr = 1'b1; addr = 16'h2007; wdata = 8'h33;
      e_we = 1'b1; e_bank = 1'b0; e_ofs = 6'd7; e_wdata = 8'h44;
      #1 chk("R9 target write accepted", {31'd0, we}, 32'd1);
      @(negedge clk);
      drive_idle(); rd = 1'b1;
      #1 chk("R9 collision target view", {24'd0, ordata}, 32'h44);
      e_ofs = 6'd7;
      #1 chk("R9 collision emu view", {24'd0, erdata}, 32'h44);

      // R7: privileged write into a read-only bank B
      @(negedge clk);
      pos = 8'h92; mode = 4'b0100; addr = 16'h9003; rd = 1'b0; wr = 1'b1; wdata = 8'h01;
      e_we = 1'b1; e_bank = 1'b1; e_ofs = 6'd3; e_wdata = 8'h6B;
      @(negedge clk);
      drive_idle(); rd = 1'b1;
      #1 chk("R7 emu write ro bank", {24'd0, ordata}, 32'h6B);
      chk("R4 bank B index", {19'd0, oaddr}, {19'd0, 13'h1003});

      @(negedge clk);
      drive_idle();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule